// File: doc/BRIEF.md
# Current-Chopping H-Bridge Controller

This block is the digital sequencer for one H-bridge whose winding current is held by fixed-frequency chopping. A free-running counter splits time into PWM periods of `PERIOD_CYC` clocks. Every period opens with the bridge driving, with each output leg following its own command input. The current-trip comparator is masked for the first `BLANK_CYC` clocks. That mask also sets the shortest on-time. After the mask, a trip ends the drive phase, and the bridge then decays in the chosen way until the next period begins.

Three decay styles are offered. Slow decay recirculates the current through both low-side switches. Fast decay reverses both legs until a near-zero indication arrives, and then all switches open. Mixed decay runs fast first and changes to slow from three quarters of the period onward. A 2-bit level code scales the external reference DAC. Its all-ones value disables the bridge for the whole period. The level and decay settings take effect only at a period boundary. The four gate enables are registered, and no leg ever switches directly between its high and low switch.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: After blanking and until a trip is taken, each leg follows its command bit: 1 asserts that leg's high-side enable and 0 asserts its low-side enable. Enables appear one clock after the phase that calls for them.
- R2: Each period (count 0 to `PERIOD_CYC-1`) opens in the drive phase unless disabled. `trip_i` has no effect while the count is below `BLANK_CYC`.
- R3: `trip_i` seen in the drive phase at a count of at least `BLANK_CYC`, and below the last count, ends drive for the rest of that period.
- R4: Level code 11 turns every enable off for the whole period. `ref_scale` presents the latched level code (00 = 100 %, 01 = 71 %, 10 = 38 %).
- R5: In slow decay both low-side enables are asserted.
- R6: In fast decay each leg takes the opposite of its command. Once `near_zero_i` is seen in fast decay, all enables stay off for the rest of the period (except the mixed switch in R7).
- R7: In mixed decay, the bridge is in slow decay at every count of at least 3/4 of `PERIOD_CYC` that falls after the trip, and in fast decay before that.
- R8: `decay_sel` encoding: 00 selects slow (driven low), 10 selects fast (driven high), and 01 (undriven) or 11 selects mixed.
- R9: No leg has its high and low enables asserted together. A leg moving between high and low spends exactly one clock with both enables off.
- R10: `level_code` and `decay_sel` are sampled only at the period boundary. Changes during a period leave `ref_scale` and the decay style unchanged.
- R11: While reset is held, all enables are 0 and `ref_scale` is 00. The first period starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_leg1 | input | 1 | Direction/PWM command for leg 1 |
| cmd_leg2 | input | 1 | Direction/PWM command for leg 2 |
| level_code | input | 2 | Current-level code; 11 disables |
| decay_sel | input | 2 | Decay style select |
| trip_i | input | 1 | Current-trip comparator output |
| near_zero_i | input | 1 | Winding current near zero |
| leg1_hi | output | 1 | Leg 1 high-side enable |
| leg1_lo | output | 1 | Leg 1 low-side enable |
| leg2_hi | output | 1 | Leg 2 high-side enable |
| leg2_lo | output | 1 | Leg 2 low-side enable |
| ref_scale | output | 2 | Latched reference-scale code for the DAC |

## Verification
The bench uses a short period and sweeps every level code, every decay-select value and every command pair. These are crossed with trip times before, at and after the blanking edge, one trip in the mixed-decay region and one on the final count, plus near-zero arrivals early, late and never. Trips placed before blanking tell masking apart from acceptance. Trips placed around the 3/4 point tell the mixed split apart from plain fast or slow decay. The near-zero timing tells fast-decay shut-off apart from continued reversal. Level and decay inputs are scrambled in mid-period, so that sampling at the boundary can be told apart from live use. Changes of command between periods exercise the one-cycle dead time.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
// Shared types for the current-chopping bridge controller.
// Assumes: one phase value is in force per clock; leg states are mutually exclusive.
package chop_pkg;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,   // all switches open
        PH_DRIVE = 3'd1,   // legs follow commands
        PH_FAST  = 3'd2,   // legs reversed
        PH_SLOW  = 3'd3,   // both low sides on
        PH_DIS   = 3'd4    // period disabled by level code
    } phase_e;

    typedef enum logic [1:0] {
        DEC_SLOW  = 2'd0,
        DEC_MIXED = 2'd1,
        DEC_FAST  = 2'd2
    } decay_e;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;

    // Map the three-level select pin encoding onto a decay style.
    function automatic decay_e decode_decay(input logic [1:0] sel);
        case (sel)
            2'b00:   return DEC_SLOW;
            2'b10:   return DEC_FAST;
            default: return DEC_MIXED;
        endcase
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
`timescale 1ns/1ps
// Free-running PWM period counter with blanking and mixed-split flags.
// Assumes: BLANK_CYC < PERIOD_CYC and 1 <= MIX_CYC <= PERIOD_CYC-1.
// Reset parks the count on the last value so the first period starts on release.
module chop_period_timer #(
    parameter int PERIOD_CYC = 2500,
    parameter int BLANK_CYC  = 188,
    parameter int MIX_CYC    = 1875,
    parameter int CW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          blank_over,
    output logic          mix_next
);

    localparam logic [CW-1:0] LAST    = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] BLANK_W = CW'(BLANK_CYC);
    localparam logic [CW-1:0] MIX_M1  = CW'(MIX_CYC - 1);

    assign wrap       = (cnt == LAST);
    assign blank_over = (cnt >= BLANK_W);
    assign mix_next   = (cnt >= MIX_M1);

    // Advance the count, restarting at zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= LAST;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/chop_phase_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: drive, then slow / fast / mixed decay until the period ends.
// Assumes: wrap marks the last cycle of a period; level and decay settings are
// latched only on that cycle.
module chop_phase_ctrl
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  logic       blank_over,
    input  logic       mix_next,
    input  logic [1:0] level_code,
    input  logic [1:0] decay_sel,
    input  logic       trip_i,
    input  logic       near_zero_i,
    output phase_e     phase,
    output logic [1:0] ref_scale
);

    decay_e     dec_q, dec_n;
    phase_e     ph_n;
    logic [1:0] lvl_n;

    // Next phase and next latched settings.
    always_comb begin
        ph_n  = phase;
        dec_n = dec_q;
        lvl_n = ref_scale;
        if (wrap) begin
            lvl_n = level_code;
            dec_n = decode_decay(decay_sel);
            ph_n  = (level_code == 2'b11) ? PH_DIS : PH_DRIVE;
        end else begin
            case (phase)
                PH_DRIVE: begin
                    if (trip_i && blank_over) begin
                        if (dec_q == DEC_SLOW || (dec_q == DEC_MIXED && mix_next))
                            ph_n = PH_SLOW;
                        else
                            ph_n = PH_FAST;
                    end
                end
                PH_FAST: begin
                    if (dec_q == DEC_MIXED && mix_next) ph_n = PH_SLOW;
                    else if (near_zero_i)              ph_n = PH_OFF;
                end
                PH_OFF: begin
                    if (dec_q == DEC_MIXED && mix_next) ph_n = PH_SLOW;
                end
                default: ph_n = phase;
            endcase
        end
    end

    // Register phase and period settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OFF;
            dec_q     <= DEC_SLOW;
            ref_scale <= 2'b00;
        end else begin
            phase     <= ph_n;
            dec_q     <= dec_n;
            ref_scale <= lvl_n;
        end
    end

endmodule

// File: rtl/chop_leg_drive.sv
`timescale 1ns/1ps
// One output leg: picks the wanted leg state from the phase and the command bit,
// and inserts a single all-off clock whenever the leg swaps high and low.
// Assumes: enables are registered; reset opens both switches.
module chop_leg_drive
    import chop_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   cmd,
    output logic   hi_en,
    output logic   lo_en
);

    leg_e want, applied, applied_n;

    // Wanted leg state for the current phase.
    always_comb begin
        case (phase)
            PH_DRIVE: want = cmd ? LEG_HI : LEG_LO;
            PH_FAST:  want = cmd ? LEG_LO : LEG_HI;
            PH_SLOW:  want = LEG_LO;
            default:  want = LEG_OFF;
        endcase
    end

    // Dead-time rule: a direct high/low swap passes through off.
    always_comb begin
        if ((applied == LEG_HI && want == LEG_LO) || (applied == LEG_LO && want == LEG_HI))
            applied_n = LEG_OFF;
        else
            applied_n = want;
    end

    // Register the applied leg state.
    always_ff @(posedge clk) begin
        if (!rst_n) applied <= LEG_OFF;
        else        applied <= applied_n;
    end

    assign hi_en = (applied == LEG_HI);
    assign lo_en = (applied == LEG_LO);

endmodule

// File: rtl/chop_bridge_ctrl.sv
`timescale 1ns/1ps
// Current-chopping H-bridge controller top.
// Assumes: trip and near-zero inputs are already synchronous to clk; the
// period, blanking and mixed split are clock counts derived from parameters.
module chop_bridge_ctrl
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 2500,
    parameter int BLANK_CYC  = 188
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_leg1,
    input  logic       cmd_leg2,
    input  logic [1:0] level_code,
    input  logic [1:0] decay_sel,
    input  logic       trip_i,
    input  logic       near_zero_i,
    output logic       leg1_hi,
    output logic       leg1_lo,
    output logic       leg2_hi,
    output logic       leg2_lo,
    output logic [1:0] ref_scale
);

    localparam int MIX_CYC = (PERIOD_CYC * 3) / 4;
    localparam int CW      = $clog2(PERIOD_CYC);
    localparam int NLEG    = 2;

    logic [CW-1:0]   cnt;
    logic            wrap, blank_over, mix_next;
    phase_e          phase;
    logic [NLEG-1:0] cmd, hi_en, lo_en;

    assign cmd = {cmd_leg2, cmd_leg1};

    chop_period_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .BLANK_CYC  (BLANK_CYC),
        .MIX_CYC    (MIX_CYC),
        .CW         (CW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .wrap       (wrap),
        .blank_over (blank_over),
        .mix_next   (mix_next)
    );

    chop_phase_ctrl u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .blank_over  (blank_over),
        .mix_next    (mix_next),
        .level_code  (level_code),
        .decay_sel   (decay_sel),
        .trip_i      (trip_i),
        .near_zero_i (near_zero_i),
        .phase       (phase),
        .ref_scale   (ref_scale)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        chop_leg_drive u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .cmd   (cmd[g]),
            .hi_en (hi_en[g]),
            .lo_en (lo_en[g])
        );
    end

    assign leg1_hi = hi_en[0];
    assign leg1_lo = lo_en[0];
    assign leg2_hi = hi_en[1];
    assign leg2_lo = lo_en[1];

endmodule

// File: rtl/chop_bridge_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for chop_bridge_ctrl, attached by bind below.
// Assumes: observes the period count and phase of the bound instance.
module chop_bridge_ctrl_chk
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 2500,
    parameter int BLANK_CYC  = 188,
    parameter int CW         = $clog2(PERIOD_CYC)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trip_i,
    input logic          near_zero_i,
    input logic          leg1_hi,
    input logic          leg1_lo,
    input logic          leg2_hi,
    input logic          leg2_lo,
    input logic [1:0]    ref_scale,
    input logic [CW-1:0] cnt,
    input phase_e        phase
);

    localparam logic [CW-1:0] LAST    = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] BLANK_W = CW'(BLANK_CYC);

    AST_LEG1_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(leg1_hi && leg1_lo)); // R9
    AST_LEG2_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(leg2_hi && leg2_lo)); // R9
    AST_LEG1_DEAD_H: assert property (@(posedge clk) disable iff (!rst_n) leg1_hi |=> !leg1_lo); // R9
    AST_LEG1_DEAD_L: assert property (@(posedge clk) disable iff (!rst_n) leg1_lo |=> !leg1_hi); // R9
    AST_LEG2_DEAD_H: assert property (@(posedge clk) disable iff (!rst_n) leg2_hi |=> !leg2_lo); // R9
    AST_LEG2_DEAD_L: assert property (@(posedge clk) disable iff (!rst_n) leg2_lo |=> !leg2_hi); // R9
    AST_BLANK_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                         (phase == PH_DRIVE && cnt < BLANK_W) |=> (phase == PH_DRIVE)); // R2
    AST_TRIP_EXIT:   assert property (@(posedge clk) disable iff (!rst_n)
                         (phase == PH_DRIVE && trip_i && cnt >= BLANK_W && cnt != LAST)
                         |=> (phase == PH_FAST || phase == PH_SLOW)); // R3
    AST_FAST_STOP:   assert property (@(posedge clk) disable iff (!rst_n)
                         (phase == PH_FAST && near_zero_i && cnt != LAST) |=> (phase != PH_FAST)); // R6
    AST_DIS_OFF:     assert property (@(posedge clk) disable iff (!rst_n)
                         (phase == PH_DIS && $past(phase) == PH_DIS)
                         |-> !(leg1_hi || leg1_lo || leg2_hi || leg2_lo)); // R4
    AST_REF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                         (cnt != '0) |-> $stable(ref_scale)); // R10

endmodule

bind chop_bridge_ctrl chop_bridge_ctrl_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (trip_i),
    .near_zero_i (near_zero_i),
    .leg1_hi     (leg1_hi),
    .leg1_lo     (leg1_lo),
    .leg2_hi     (leg2_hi),
    .leg2_lo     (leg2_lo),
    .ref_scale   (ref_scale),
    .cnt         (cnt),
    .phase       (phase)
);

// File: tb/chop_bridge_ctrl_tb.sv
`timescale 1ns/1ps
// Sweeping bench: every level, decay select and command pair, crossed with
// trip and near-zero timings; expected enables computed by cycle counting.
module chop_bridge_ctrl_tb;

    localparam int P = 32;
    localparam int B = 5;
    localparam int M = (P * 3) / 4;
    localparam int NEVER = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_leg1 = 1'b0, cmd_leg2 = 1'b0;
    logic [1:0] level_code = 2'b00, decay_sel = 2'b00;
    logic       trip_i = 1'b0, near_zero_i = 1'b0;
    logic       leg1_hi, leg1_lo, leg2_hi, leg2_lo;
    logic [1:0] ref_scale;

    int    n_chk = 0, n_err = 0;
    bit    done = 0;
    int    ph_prev = 0, app1 = 0, app2 = 0;
    string tag_prev = "R11";

    always #4 clk = ~clk;

    chop_bridge_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_leg1(cmd_leg1), .cmd_leg2(cmd_leg2),
        .level_code(level_code), .decay_sel(decay_sel), .trip_i(trip_i),
        .near_zero_i(near_zero_i), .leg1_hi(leg1_hi), .leg1_lo(leg1_lo),
        .leg2_hi(leg2_hi), .leg2_lo(leg2_lo), .ref_scale(ref_scale)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Leg codes: 0 off, 1 high side, 2 low side, 3 both.
    function automatic int want_of(int ph, logic d);
        case (ph)
            1:       return d ? 1 : 2;
            2:       return d ? 2 : 1;
            3:       return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int dead(int prev, int w);
        return ((prev == 1 && w == 2) || (prev == 2 && w == 1)) ? 0 : w;
    endfunction

    // Phases: 0 off, 1 drive, 2 fast, 3 slow.
    function automatic int ph_at(int c, int lvl, int dec, int tc, int z);
        int zo;
        if (lvl == 3)                    return 0;
        if (c <= tc)                     return 1;
        if (dec == 0)                    return 3;
        if (dec != 2 && c >= M)          return 3;
        zo = ((z > tc + 1) ? z : tc + 1) + 1;
        if (c >= zo)                     return 0;
        return 2;
    endfunction

    task automatic run_period(input int d1, input int d2, input int lvl, input int dec,
                              input int t, input int z);
        int tc;
        tc = (t > B) ? t : B;
        if (t >= P) tc = NEVER;
        cmd_leg1 = d1[0]; cmd_leg2 = d2[0];
        level_code = lvl[1:0]; decay_sel = dec[1:0];
        trip_i = 1'b0; near_zero_i = 1'b0;
        for (int c = 0; c < P; c++) begin
            int w1, w2, n1, n2, a1, a2, ph;
            string tg;
            @(negedge clk);
            w1 = want_of(ph_prev, cmd_leg1);
            w2 = want_of(ph_prev, cmd_leg2);
            n1 = dead(app1, w1);
            n2 = dead(app2, w2);
            tg = tag_prev;
            if ((n1 == 0 && w1 != 0) || (n2 == 0 && w2 != 0)) tg = "R9";
            a1 = (leg1_hi ? 1 : 0) + (leg1_lo ? 2 : 0);
            a2 = (leg2_hi ? 1 : 0) + (leg2_lo ? 2 : 0);
            check((a1 == n1) && (a2 == n2), tg, a1 * 4 + a2, n1 * 4 + n2);
            app1 = n1; app2 = n2;
            check(ref_scale == lvl[1:0], "R4 R10 ref_scale", int'(ref_scale), lvl);
            trip_i      = (c >= t);
            near_zero_i = (c >= z);
            ph = ph_at(c, lvl, dec, tc, z);
            ph_prev = ph;
            case (ph)
                1:       tg = (c < B) ? "R2" : "R1";
                2:       tg = "R3 R6 R8";
                3:       tg = (dec == 0) ? "R3 R5 R8" : "R7 R8";
                default: tg = (lvl == 3) ? "R4" : "R6";
            endcase
            tag_prev = tg;
            if (c == P / 2) begin
                level_code = ~lvl[1:0];
                decay_sel  = ~dec[1:0];
            end
        end
    endtask

    initial begin
        int tlist[8];
        int zlist[3];
        tlist = '{0, 3, B, 7, 17, 26, P - 1, 99};
        zlist = '{4, 20, 99};
        repeat (3) @(negedge clk);
        check(!(leg1_hi || leg1_lo || leg2_hi || leg2_lo), "R11 enables in reset",
              int'({leg1_hi, leg1_lo, leg2_hi, leg2_lo}), 0);
        check(ref_scale == 2'b00, "R11 ref_scale in reset", int'(ref_scale), 0);
        rst_n = 1'b1;
        for (int lvl = 0; lvl < 4; lvl++)
            for (int dec = 0; dec < 4; dec++)
                for (int d = 0; d < 4; d++)
                    for (int ti = 0; ti < 8; ti++)
                        for (int zi = 0; zi < 3; zi++)
                            run_period(d & 1, (d >> 1) & 1, lvl, dec, tlist[ti], zlist[zi]);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1..: got 0 expected 1 (run did not complete)");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule